// File: doc/BRIEF.md
# Translation Buffer with Large-Page Matching and Access Rights

This block is a fully associative address translation buffer with eight entries. Each entry maps either a normal 8 KB page or a large 16 MB page. A page-table walker fills entries through a one-cycle fill port. The processor side presents lookups with three qualifiers: instruction fetch or data access, read or write, and user or supervisor. One cycle later the block returns exactly one of three results. A hit carries the physical address. A miss tells the walker to fetch the mapping. A protection fault reports that the mapping exists but does not allow the access.

Each entry keeps a 3-bit rights code that both the instruction and the data side decode, plus an accessed flag and a dirty flag. Replacement is round-robin. Entry 0 can be pinned so that a permanent kernel mapping survives every refill. The entry that the next fill will overwrite is always visible at the outputs, so the walker can write its status back before replacing it.

The result is held in a small state register. The states are `RS_IDLE` (no response), `RS_HIT`, `RS_MISS` and `RS_FAULT`, and any state can move to any other on each clock edge:
- to `RS_IDLE` when no lookup is presented, or when a fill occupies the cycle;
- to `RS_MISS` when no usable entry matches;
- to `RS_FAULT` when an entry matches but the rights check fails;
- to `RS_HIT` otherwise.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no response is given (`rsp_valid`=0) and every entry is empty: `victim_idx`=0 and `victim_live`=0.
- R2: A normal entry (huge flag 0) matches when `lk_vaddr[31:13]` equals its stored page number. A hit returns `{ppn, lk_vaddr[12:0]}` on `rsp_paddr` in the cycle after the lookup. If several entries match, the lowest index wins.
- R3: A huge entry compares only `lk_vaddr[31:24]` with bits 18:11 of its stored page number. It returns `{ppn[18:11], lk_vaddr[23:0]}`, so every 8 KB sub-page inside the 16 MB region hits.
- R4: The rights code uses three bits. Bit 0 is the usable flag: it means readable for data and executable for instruction fetch. An entry with bit 0 clear never matches, so a lookup that finds only such entries reports a miss.
- R5: A fault is reported instead of a hit in two cases: a data write to an entry whose rights bit 2 (writable) is clear, or a user request to an entry whose bit 1 (user) is clear. On instruction fetches the write input is ignored.
- R6: A hit sets the entry's accessed flag. A data write hit also sets its dirty flag. A miss or a fault changes neither flag, and a fill clears both.
- R7: A fill writes the entry named by `victim_idx`. After the fill, `victim_idx` advances by one, wrapping from 7 to 0.
- R8: While `lock_entry0` is 1, `victim_idx` is never 0. The pointer skips entry 0, and the mapping held there is not overwritten.
- R9: When a fill and a lookup arrive in the same cycle, the fill is performed and the lookup is dropped: `rsp_valid` is 0 in the next cycle.
- R10: A lookup that matches no entry reports a miss. On a miss or a fault `rsp_paddr` is 0.
- R11: `victim_live`, `victim_vpn`, `victim_accessed` and `victim_dirty` show the occupied flag, the stored page number and the two status flags of the entry named by `victim_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Data write (ignored for fetches) |
| lk_user | input | 1 | Request made in user mode |
| lk_instr | input | 1 | Instruction fetch (1) or data access (0) |
| fill_valid | input | 1 | Write a new mapping into the victim entry |
| fill_vpn | input | 19 | Virtual page number (bits 31:13) |
| fill_ppn | input | 19 | Physical page number (bits 31:13) |
| fill_huge | input | 1 | Mapping is a 16 MB page |
| fill_prot | input | 3 | Rights code: bit 2 writable, bit 1 user, bit 0 usable |
| lock_entry0 | input | 1 | Keep entry 0 out of replacement |
| rsp_valid | output | 1 | A result is present this cycle |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No usable matching entry |
| rsp_fault | output | 1 | Matching entry forbids the access |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| victim_idx | output | 3 | Entry the next fill will overwrite |
| victim_live | output | 1 | Victim entry holds a mapping |
| victim_vpn | output | 19 | Victim entry's virtual page number |
| victim_accessed | output | 1 | Victim entry's accessed flag |
| victim_dirty | output | 1 | Victim entry's dirty flag |

## Verification
Every lookup result is due exactly one clock edge after the request. Inputs change at the falling edge, so the response is sampled at the next falling edge, one rising edge later. A fill and the flag updates from a hit also take effect at that same rising edge. For this reason the victim outputs are compared after each operation against a bench model that has already applied the change. The cycle that follows a combined fill and lookup is checked for the absence of any response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 13;
    localparam int HUGE_SHIFT = 24;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int HUGE_W     = VA_W - HUGE_SHIFT;
    localparam int PROT_W     = 3;

    // rights code bit positions
    localparam int PROT_OK    = 0;
    localparam int PROT_USER  = 1;
    localparam int PROT_WR    = 2;

    typedef struct packed {
        logic              live;
        logic              huge;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [PROT_W-1:0] prot;
        logic              acc;
        logic              dirty;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HIT,
        RS_MISS,
        RS_FAULT
    } rsp_state_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] live_i,
    input  logic [NUM_ENTRIES-1:0] usable_i,
    input  logic [NUM_ENTRIES-1:0] huge_i,
    input  logic [VPN_W-1:0]       vpn_i [NUM_ENTRIES],
    input  logic [VPN_W-1:0]       page_i,
    output logic                   any_o,
    output logic [IDX_W-1:0]       idx_o
);

    logic [NUM_ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic big_eq;
        logic full_eq;
        assign big_eq  = vpn_i[g][VPN_W-1 -: HUGE_W] == page_i[VPN_W-1 -: HUGE_W];
        assign full_eq = vpn_i[g] == page_i;
        assign hit_vec[g] = live_i[g] && usable_i[g] &&
                            (huge_i[g] ? big_eq : full_eq);
    end

    always_comb begin
        any_o = |hit_vec;
        idx_o = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [PROT_W-1:0] prot_i,
    input  logic              write_i,
    input  logic              user_i,
    input  logic              instr_i,
    output logic              fault_o
);

    logic wr_bad;
    logic usr_bad;

    always_comb begin
        wr_bad  = write_i && !instr_i && !prot_i[PROT_WR];
        usr_bad = user_i && !prot_i[PROT_USER];
        fault_o = wr_bad || usr_bad;
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_i,
    input  logic             advance_i,
    output logic [IDX_W-1:0] victim_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        victim_o = ptr_q;
        if (lock_i && ptr_q == '0) begin
            victim_o = IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance_i) begin
            ptr_q <= (victim_o == LAST) ? '0 : victim_o + 1'b1;
        end
    end

    a_r7_pointer_moves: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |=> victim_o != $past(victim_o));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic              lk_user,
    input  logic              lk_instr,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [VPN_W-1:0]  fill_ppn,
    input  logic              fill_huge,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              lock_entry0,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [$clog2(NUM_ENTRIES)-1:0] victim_idx,
    output logic              victim_live,
    output logic [VPN_W-1:0]  victim_vpn,
    output logic              victim_accessed,
    output logic              victim_dirty
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);

    tlb_entry_t ent_q [NUM_ENTRIES];

    rsp_state_e state_q, state_d;
    logic [VA_W-1:0]  paddr_q, paddr_d;

    logic [NUM_ENTRIES-1:0] live_v, usable_v, huge_v;
    logic [VPN_W-1:0]       vpn_a [NUM_ENTRIES];

    logic             m_any;
    logic [IDX_W-1:0] m_idx;
    logic             m_fault;
    logic [IDX_W-1:0] v_idx;
    logic             lookup_go;
    logic             data_write;
    tlb_entry_t       sel;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_flat
        assign live_v[g]   = ent_q[g].live;
        assign usable_v[g] = ent_q[g].prot[PROT_OK];
        assign huge_v[g]   = ent_q[g].huge;
        assign vpn_a[g]    = ent_q[g].vpn;
    end

    tlb_match #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_match (
        .live_i   (live_v),
        .usable_i (usable_v),
        .huge_i   (huge_v),
        .vpn_i    (vpn_a),
        .page_i   (lk_vaddr[VA_W-1 -: VPN_W]),
        .any_o    (m_any),
        .idx_o    (m_idx)
    );

    assign sel = ent_q[m_idx];

    tlb_perm u_perm (
        .prot_i  (sel.prot),
        .write_i (lk_write),
        .user_i  (lk_user),
        .instr_i (lk_instr),
        .fault_o (m_fault)
    );

    tlb_victim #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (lock_entry0),
        .advance_i (fill_valid),
        .victim_o  (v_idx)
    );

    assign lookup_go  = lk_valid && !fill_valid;
    assign data_write = lk_write && !lk_instr;

    // next result state and address
    always_comb begin
        state_d = RS_IDLE;
        paddr_d = '0;
        if (lookup_go) begin
            if (!m_any) begin
                state_d = RS_MISS;
            end else if (m_fault) begin
                state_d = RS_FAULT;
            end else begin
                state_d = RS_HIT;
                if (sel.huge) begin
                    paddr_d = {sel.ppn[VPN_W-1 -: HUGE_W], lk_vaddr[HUGE_SHIFT-1:0]};
                end else begin
                    paddr_d = {sel.ppn, lk_vaddr[PAGE_SHIFT-1:0]};
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= paddr_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        rsp_valid = 1'b1;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            RS_IDLE:  rsp_valid = 1'b0;
            RS_HIT:   rsp_hit   = 1'b1;
            RS_MISS:  rsp_miss  = 1'b1;
            RS_FAULT: rsp_fault = 1'b1;
        endcase
    end

    assign rsp_paddr = paddr_q;

    // entry storage: fill first, then status of a hit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else if (fill_valid) begin
            ent_q[v_idx] <= '{live:  1'b1,
                              huge:  fill_huge,
                              vpn:   fill_vpn,
                              ppn:   fill_ppn,
                              prot:  fill_prot,
                              acc:   1'b0,
                              dirty: 1'b0};
        end else if (state_d == RS_HIT) begin
            ent_q[m_idx].acc <= 1'b1;
            if (data_write) begin
                ent_q[m_idx].dirty <= 1'b1;
            end
        end
    end

    assign victim_idx      = v_idx;
    assign victim_live     = ent_q[v_idx].live;
    assign victim_vpn      = ent_q[v_idx].vpn;
    assign victim_accessed = ent_q[v_idx].acc;
    assign victim_dirty    = ent_q[v_idx].dirty;

    a_r9_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !rsp_valid);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r5_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !fill_valid ##1 rsp_fault |->
            $past(lk_user) || ($past(lk_write) && !$past(lk_instr)));

    a_r6_write_hit_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !fill_valid && lk_write && !lk_instr ##1 rsp_hit |->
            ent_q[$past(m_idx)].dirty && ent_q[$past(m_idx)].acc);

    a_r8_locked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lock_entry0 && $past(lock_entry0) |->
            $stable(ent_q[0].vpn) && $stable(ent_q[0].ppn) && $stable(ent_q[0].huge));

    a_r10_miss_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_fault) |-> rsp_paddr == '0);

endmodule

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0, lk_user = 0, lk_instr = 0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_valid = 0, fill_huge = 0, lock_entry0 = 0;
    logic [18:0] fill_vpn = '0, fill_ppn = '0;
    logic [2:0]  fill_prot = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  victim_idx;
    logic        victim_live, victim_accessed, victim_dirty;
    logic [18:0] victim_vpn;

    always #2.5 clk = ~clk;

    tlb_xlate i_tlb_xlate (.*);

    int n_cmp = 0, n_bad = 0;

    bit        m_live[8], m_huge[8], m_acc[8], m_dirty[8];
    logic [18:0] m_vpn[8], m_ppn[8];
    logic [2:0]  m_prot[8];
    int        m_ptr = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int m_victim();
        return (lock_entry0 && m_ptr == 0) ? 1 : m_ptr;
    endfunction

    task automatic check_victim();
        int v = m_victim();
        check("R7 victim index", 32'(victim_idx), 32'(v));
        check("R11 victim live", 32'(victim_live), 32'(m_live[v]));
        check("R11 victim vpn", 32'(victim_vpn), 32'(m_vpn[v]));
        check("R6 victim accessed", 32'(victim_accessed), 32'(m_acc[v]));
        check("R6 victim dirty", 32'(victim_dirty), 32'(m_dirty[v]));
    endtask

    task automatic model_fill(logic [18:0] vpn, logic [18:0] ppn, bit huge, logic [2:0] prot);
        int v = m_victim();
        m_live[v] = 1; m_huge[v] = huge; m_vpn[v] = vpn; m_ppn[v] = ppn;
        m_prot[v] = prot; m_acc[v] = 0; m_dirty[v] = 0;
        m_ptr = (v + 1) % 8;
    endtask

    task automatic drive_fill(logic [18:0] vpn, logic [18:0] ppn, bit huge, logic [2:0] prot);
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_huge = huge; fill_prot = prot;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic do_fill(logic [18:0] vpn, logic [18:0] ppn, bit huge, logic [2:0] prot);
        drive_fill(vpn, ppn, huge, prot);
        @(negedge clk);
        fill_valid = 0;
        model_fill(vpn, ppn, huge, prot);
        check("R9 no response after fill", 32'(rsp_valid), 32'd0);
        check_victim();
    endtask

    task automatic do_look(logic [31:0] va, bit w, bit u, bit ins);
        int idx = -1;
        bit exp_fault;
        logic [31:0] exp_pa = '0;
        string req;
        for (int i = 7; i >= 0; i--) begin
            if (m_live[i] && m_prot[i][0] &&
                (m_huge[i] ? (m_vpn[i][18:11] == va[31:24]) : (m_vpn[i] == va[31:13])))
                idx = i;
        end
        lk_valid = 1; lk_vaddr = va; lk_write = w; lk_user = u; lk_instr = ins;
        @(negedge clk);
        lk_valid = 0;
        check("R2 response present", 32'(rsp_valid), 32'd1);
        if (idx < 0) begin
            check("R10 miss", {rsp_hit, rsp_miss, rsp_fault}, 32'b010);
            check("R10 miss address", rsp_paddr, 32'd0);
        end else begin
            exp_fault = (w && !ins && !m_prot[idx][2]) || (u && !m_prot[idx][1]);
            if (exp_fault) begin
                check("R5 fault", {rsp_hit, rsp_miss, rsp_fault}, 32'b001);
                check("R5 fault address", rsp_paddr, 32'd0);
            end else begin
                exp_pa = m_huge[idx] ? {m_ppn[idx][18:11], va[23:0]} : {m_ppn[idx], va[12:0]};
                req = m_huge[idx] ? "R3 huge hit" : "R2 normal hit";
                check(req, {rsp_hit, rsp_miss, rsp_fault}, 32'b100);
                check(req, rsp_paddr, exp_pa);
                m_acc[idx] = 1;
                if (w && !ins) m_dirty[idx] = 1;
            end
        end
        check_victim();
    endtask

    task automatic do_both(logic [18:0] vpn, logic [18:0] ppn, bit huge, logic [2:0] prot, logic [31:0] va);
        drive_fill(vpn, ppn, huge, prot);
        lk_valid = 1; lk_vaddr = va; lk_write = 1; lk_user = 0; lk_instr = 0;
        @(negedge clk);
        fill_valid = 0; lk_valid = 0;
        model_fill(vpn, ppn, huge, prot);
        check("R9 lookup dropped", 32'(rsp_valid), 32'd0);
        check_victim();
    endtask

    function automatic logic [7:0] pick_hi(int r);
        case (r % 3)
            0: return 8'h00;
            1: return 8'hC0;
            default: return 8'h3F;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20130730));
        for (int i = 0; i < 8; i++) begin
            m_live[i] = 0; m_huge[i] = 0; m_acc[i] = 0; m_dirty[i] = 0;
            m_vpn[i] = '0; m_ppn[i] = '0; m_prot[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 no response in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 no response", 32'(rsp_valid), 32'd0);
        check("R1 empty victim", {victim_idx, victim_live}, 32'd0);

        // huge supervisor-writable mapping
        do_fill({8'hC0, 11'h0}, {8'h01, 11'h0}, 1, 3'b101);
        do_look(32'hC012_3456, 0, 0, 0);   // R3 sub-page hit
        do_look(32'hC0FF_E000, 1, 0, 0);   // R3 other sub-page, write
        do_look(32'hC100_0000, 0, 0, 0);   // R10 miss
        do_look(32'hC000_0000, 0, 1, 0);   // R5 user fault
        // normal page full rights
        do_fill(19'h00201, 19'h12345, 0, 3'b111);
        do_look(32'h0040_2ABC, 0, 1, 0);   // R2
        do_look(32'h0040_4000, 0, 0, 0);   // R10 neighbour page
        // unusable entry (bit 0 clear)
        do_fill(19'h00300, 19'h00055, 0, 3'b110);
        do_look(32'h0060_0010, 0, 0, 0);   // R4 miss
        do_look(32'h0060_0010, 0, 0, 1);   // R4 fetch miss
        // read-only user page
        do_fill(19'h00400, 19'h00077, 0, 3'b011);
        do_look(32'h0080_0004, 1, 1, 1);   // R5 fetch ignores write
        do_look(32'h0080_0004, 1, 1, 0);   // R5 write fault
        // duplicate mapping: lowest index wins (R2)
        do_fill(19'h00201, 19'h00999, 0, 3'b111);
        do_look(32'h0040_2000, 0, 0, 0);

        // pin entry 0 and wrap twice (R8)
        lock_entry0 = 1;
        @(negedge clk);
        check_victim();
        for (int k = 0; k < 16; k++) begin
            do_fill(19'(32'h100 + k), 19'(k), 0, 3'b111);
            check("R8 victim never zero", 32'(victim_idx != 0), 32'd1);
        end
        do_look(32'hC0AB_CDEF, 0, 0, 0);   // R8 kernel mapping kept
        do_both(19'h00500, 19'h00123, 0, 3'b111, 32'hC000_0000);
        do_look(32'h00A0_0100, 1, 0, 0);   // R9 filled entry usable
        lock_entry0 = 0;
        @(negedge clk);
        check_victim();

        // constrained random traffic
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom % 100;
            logic [31:0] va = {pick_hi($urandom), 11'($urandom % 4), 13'($urandom)};
            if (r < 20) begin
                do_fill({pick_hi($urandom), 11'($urandom % 4)}, 19'($urandom),
                        ($urandom % 4) == 0, 3'($urandom));
            end else if (r < 23) begin
                do_both({pick_hi($urandom), 11'($urandom % 4)}, 19'($urandom),
                        ($urandom % 4) == 0, 3'($urandom | 1), va);
            end else if (r < 25) begin
                lock_entry0 = ~lock_entry0;
                @(negedge clk);
                check_victim();
            end else begin
                do_look(va, $urandom % 2, $urandom % 2, ($urandom % 3) == 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule